// File: doc/BRIEF.md
# Three-Output Power-of-Two Clock Divider

This block takes one source clock and derives three gated clocks from it, named high, medium and low. Each output has its own 3-bit divide code and its own enable bit. The codes and enables share one 32-bit control word, which is written through a single write strobe and can be read back at any time. The divide ratio is a power of two. Code 0 and code 1 both pass the source clock straight through, and code 7 divides by 64.

A change to an enable first passes through a two-flop synchroniser. It then takes effect on the falling edge of the source clock, but only while that output's divided phase is low. At that same moment the output's acknowledge flag is updated. Software sets or clears any mix of enables in one write, then waits until every acknowledge it asked for reads 1. A new divide code is applied at the same kind of safe low point, and the divider count restarts from zero. Because of this, no output ever shows a runt pulse, and a disabled output stays low.

Top module: `tri_clk_divider`

## Requirements
- R1: After reset the control word reads 0 (all codes, enables and acknowledges 0) and all three outputs are low.
- R2: Divide codes sit at bits [2:0] (high), [10:8] (medium) and [18:16] (low), and enables sit at bits 24, 25 and 26. A write stores these fields, and a read returns them unchanged.
- R3: Writes to bits 28 to 30 and to unused bits have no effect. Unused bits always read 0.
- R4: With code k from 1 to 7 and the output enabled, the output is a clock with period 2^(k-1) source cycles. For k of 2 or more it is high for half of that period. Code 1 follows the source clock.
- R5: Code 0 gives the same output as code 1, which is the source clock passed through.
- R6: An output whose acknowledge reads 0 is held low and does not toggle.
- R7: The acknowledge of the high, medium and low output is bit 28, 29 and 30, four above its enable. It takes the value of the enable on the first falling source edge, at least two cycles after the enable changed, at which the output's divided phase is low.
- R8: A change to an enable or a divide code is applied only while the output is low. After a change the output starts a full low phase, so no high pulse is shorter than the old or new setting gives.
- R9: The three outputs run independently, and one write may enable or disable several of them together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock; also clocks the register port |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Control word write data |
| rd_data_o | output | 32 | Control word read data, including acknowledges |
| div_clk_o | output | 3 | Divided clocks: bit 0 high, bit 1 medium, bit 2 low |

## Verification
The hardest case to reach is a divide code rewritten on an output that is already running, at a moment when its divided phase is high. This case is where a runt pulse would appear. The bench reaches it by rewriting the codes of enabled outputs, from fast to slow and from slow to fast, without first waiting for them to go low. It compares the outputs against a behavioural model in the middle of both halves of every source cycle, and it also measures the shortest complete high run. Disabling and enabling several outputs in one write checks that the acknowledges can land together.

// File: rtl/tri_clk_divider.sv
module tri_clk_divider #(
  parameter int NOUT        = 3,
  parameter int CODE_W      = 3,
  parameter int DW          = 32,
  parameter int CODE_STRIDE = 8,
  parameter int EN_LSB      = 24,
  parameter int ACK_GAP     = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o,
  output logic [NOUT-1:0] div_clk_o
);
  localparam int MAXSH   = (1 << CODE_W) - 2;
  localparam int CNT_W   = (MAXSH < 1) ? 1 : MAXSH;
  localparam int ACK_LSB = EN_LSB + ACK_GAP;

  logic [NOUT-1:0][CODE_W-1:0] code_q;
  logic [NOUT-1:0]             en_q;
  logic [NOUT-1:0]             ack;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      en_q   <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < NOUT; i++) begin
        code_q[i] <= wr_data_i[i*CODE_STRIDE +: CODE_W];
        en_q[i]   <= wr_data_i[EN_LSB+i];
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NOUT; i++) begin
      rd_data_o[i*CODE_STRIDE +: CODE_W] = code_q[i];
      rd_data_o[EN_LSB+i]  = en_q[i];
      rd_data_o[ACK_LSB+i] = ack[i];
    end
  end

  for (genvar g = 0; g < NOUT; g++) begin : g_ch
    logic              s1, s2, aen, sen, ph, ph_nxt, pend;
    logic [CODE_W-1:0] acode, scode, sh;
    logic [CNT_W-1:0]  cnt, cnt_nxt, lim;
    logic [CNT_W:0]    nper;

    assign sh      = (acode == '0) ? '0 : acode - 1'b1;
    assign nper    = (CNT_W+1)'(1) << sh;
    assign lim     = CNT_W'(nper - 1'b1);
    assign cnt_nxt = (cnt == lim) ? '0 : cnt + 1'b1;
    assign ph_nxt  = (sh != '0) && ({1'b0, cnt_nxt} >= (nper >> 1));
    assign pend    = (aen != sen) || (acode != scode);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1 <= 1'b0; s2 <= 1'b0; sen <= 1'b0; scode <= '0;
        cnt <= '0;  ph <= 1'b0;
      end else begin
        s1 <= en_q[g];
        s2 <= s1;
        if (pend) begin
          sen <= aen; scode <= acode; cnt <= '0; ph <= 1'b0;
        end else if (aen && sh != '0) begin
          cnt <= cnt_nxt; ph <= ph_nxt;
        end else begin
          cnt <= '0; ph <= 1'b0;
        end
      end
    end

    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        aen   <= 1'b0;
        acode <= '0;
      end else if (!ph && (s2 != aen || code_q[g] != acode)) begin
        aen   <= s2;
        acode <= code_q[g];
      end
    end

    assign ack[g]       = aen;
    assign div_clk_o[g] = aen & ((sh == '0) ? clk_i : ph);
  end
endmodule

// File: rtl/tri_clk_divider_chk.sv
module tri_clk_divider_chk #(
  parameter int NOUT        = 3,
  parameter int CODE_W      = 3,
  parameter int DW          = 32,
  parameter int CODE_STRIDE = 8,
  parameter int EN_LSB      = 24,
  parameter int ACK_GAP     = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [DW-1:0]   rd_data_o,
  input logic [NOUT-1:0] div_clk_o
);
  localparam int ACK_LSB = EN_LSB + ACK_GAP;
  logic [DW-1:0] valid;

  always_comb begin
    valid = '0;
    for (int i = 0; i < NOUT; i++) begin
      valid[i*CODE_STRIDE +: CODE_W] = '1;
      valid[EN_LSB+i]  = 1'b1;
      valid[ACK_LSB+i] = 1'b1;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (rd_data_o == '0 && div_clk_o == '0));

  assert_unused_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & ~valid) == '0);

  for (genvar g = 0; g < NOUT; g++) begin : g_a
    assert_quiet_when_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_data_o[ACK_LSB+g] |-> !div_clk_o[g]);

    assert_ack_after_sync_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rd_data_o[ACK_LSB+g]) |-> $past(rd_data_o[EN_LSB+g], 2));

    assert_switch_when_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(rd_data_o[ACK_LSB+g]) |-> !div_clk_o[g]);
  end
endmodule

bind tri_clk_divider tri_clk_divider_chk #(
  .NOUT(NOUT), .CODE_W(CODE_W), .DW(DW), .CODE_STRIDE(CODE_STRIDE),
  .EN_LSB(EN_LSB), .ACK_GAP(ACK_GAP)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_data_o(rd_data_o), .div_clk_o(div_clk_o)
);

// File: tb/tri_clk_divider_test.sv
module tri_clk_divider_test;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd;
  logic [2:0]  dclk;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tri_clk_divider uut (.clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en),
                       .wr_data_i(wr_data), .rd_data_o(rd), .div_clk_o(dclk));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_rng(string tag, int v, int lo, int hi);
    checks++;
    if (v < lo || v > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, v, lo, hi);
    end
  endtask

  // behavioural reference
  int m_en[3], m_code[3], s1[3], s2[3], aen[3], acode[3], sen[3], scode[3], cnt[3], ph[3];

  function automatic int per(int c);
    return 1 << ((c == 0) ? 0 : c - 1);
  endfunction

  always @(posedge clk) begin
    for (int c = 0; c < 3; c++) begin
      if (!rst_n) begin
        m_en[c] = 0; m_code[c] = 0; s1[c] = 0; s2[c] = 0; aen[c] = 0;
        acode[c] = 0; sen[c] = 0; scode[c] = 0; cnt[c] = 0; ph[c] = 0;
      end else begin
        if (aen[c] != sen[c] || acode[c] != scode[c]) begin
          sen[c] = aen[c]; scode[c] = acode[c]; cnt[c] = 0; ph[c] = 0;
        end else if (aen[c] != 0 && per(acode[c]) > 1) begin
          cnt[c] = (cnt[c] + 1) % per(acode[c]);
          ph[c]  = (cnt[c] >= per(acode[c]) / 2) ? 1 : 0;
        end else begin
          cnt[c] = 0; ph[c] = 0;
        end
        s2[c] = s1[c];
        s1[c] = m_en[c];
        if (wr_en) begin
          m_code[c] = int'(wr_data[8*c +: 3]);
          m_en[c]   = int'(wr_data[24+c]);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n)
      for (int c = 0; c < 3; c++)
        if (ph[c] == 0 && (s2[c] != aen[c] || m_code[c] != acode[c])) begin
          aen[c] = s2[c]; acode[c] = m_code[c];
        end
  end

  function automatic logic [31:0] exp_rd();
    logic [31:0] v = '0;
    for (int c = 0; c < 3; c++) begin
      v[8*c +: 3] = 3'(m_code[c]);
      v[24+c] = (m_en[c] != 0);
      v[28+c] = (aen[c] != 0);
    end
    return v;
  endfunction

  function automatic logic exp_out(int c);
    return (aen[c] != 0) && ((per(acode[c]) == 1) ? clk : (ph[c] != 0));
  endfunction

  task automatic cmp();
    logic [31:0] e = exp_rd();
    for (int c = 0; c < 3; c++) chk("R4 output vs model", 32'(dclk[c]), 32'(exp_out(c)));
    chk("R2 control fields", rd & 32'h0707_0707, e & 32'h0707_0707);
    chk("R7 acknowledge bits", rd & 32'h7000_0000, e & 32'h7000_0000);
  endtask

  always @(posedge clk) begin #2; if (!done) cmp(); end
  always @(negedge clk) begin #2; if (!done) cmp(); end

  task automatic wr(logic [31:0] v);
    @(posedge clk); #1 wr_en = 1'b1; wr_data = v;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic observe(int c, int ncyc, output int rises, output int minhi);
    logic prev, cur;
    int run = 0;
    bit started = 0;
    rises = 0; minhi = 1000000;
    @(posedge clk); #3 prev = dclk[c];
    for (int k = 0; k < 2*ncyc; k++) begin
      if (k % 2 == 0) @(negedge clk); else @(posedge clk);
      #3 cur = dclk[c];
      if (cur && !prev) begin rises++; started = 1; run = 1; end
      else if (cur && prev) run++;
      else if (!cur && prev) begin if (started && run < minhi) minhi = run; started = 0; end
      prev = cur;
    end
  endtask

  task automatic run_tests();
    int r, mh, r2, mh2;
    repeat (5) @(posedge clk);
    #1 chk("R1 reset word", rd, 32'h0);
    chk("R1 reset outputs", 32'(dclk), 32'h0);
    @(negedge clk); #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk("R1 word after release", rd, 32'h0);

    wr(32'h7004_0302);
    chk("R3 ack write ignored", rd, 32'h0004_0302);
    chk("R2 codes stored", rd, 32'h0004_0302);
    observe(0, 40, r, mh); chk_rng("R6 disabled high", r, 0, 0);
    observe(2, 40, r, mh); chk_rng("R6 disabled low", r, 0, 0);

    wr(32'hFFFF_FFFF);
    chk("R3 unused bits dropped", rd, 32'h0707_0707);
    repeat (10) @(posedge clk);
    #1 chk("R7 acks raised", rd, 32'h7707_0707);

    wr(32'h0704_0302);
    repeat (150) @(posedge clk);
    #1 chk("R3 acks kept", rd, 32'h7704_0302);
    observe(0, 64, r, mh); chk_rng("R4 div2 rises", r, 32, 32); chk_rng("R4 div2 high", mh, 2, 2);
    observe(1, 64, r, mh); chk_rng("R4 div4 rises", r, 16, 16); chk_rng("R4 div4 high", mh, 4, 4);
    observe(2, 64, r, mh); chk_rng("R4 div8 rises", r, 8, 8);  chk_rng("R4 div8 high", mh, 8, 8);

    wr(32'h0704_0100);
    repeat (40) @(posedge clk);
    observe(0, 64, r, mh); observe(1, 64, r2, mh2);
    chk_rng("R5 code0 rises", r, 64, 64);
    chk_rng("R5 code0 high", mh, 1, 1);
    chk_rng("R5 code0 equals code1", r, r2, r2);

    wr(32'h0707_0100);
    observe(2, 200, r, mh);
    chk_rng("R8 no runt fast to slow", mh, 8, 1000000);
    wr(32'h0701_0100);
    observe(2, 100, r, mh);
    chk_rng("R8 no runt slow to fast", mh, 1, 1000000);
    observe(2, 32, r, mh); chk_rng("R8 settled pass-through", r, 32, 32);

    wr(32'h0501_0100);
    repeat (10) @(posedge clk);
    #1 chk("R7 medium ack cleared", rd & 32'h2200_0000, 32'h0);
    observe(1, 40, r, mh); chk_rng("R6 medium quiet", r, 0, 0);
    observe(0, 40, r, mh); chk_rng("R9 high unaffected", r, 40, 40);

    wr(32'h0001_0100);
    repeat (80) @(posedge clk);
    #1 chk("R9 all disabled", rd, 32'h0001_0100);
    wr(32'h0703_0201);
    repeat (5) @(posedge clk);
    #1 chk("R9 joint enable acks", rd, 32'h7703_0201);
    observe(0, 64, r, mh); chk_rng("R4 code1 rises", r, 64, 64);
    observe(1, 64, r, mh); chk_rng("R4 code2 rises", r, 32, 32);
    observe(2, 64, r, mh); chk_rng("R4 code3 rises", r, 16, 16);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule